// File: doc/BRIEF.md
# Paged Branch and Call Sequencer

This block owns the program counter of a 16-bit accumulator machine. It fetches each instruction word from a single-port memory, which has an asynchronous read and a write on the clock edge. The PC advances once per fetch. When the top nibble of the fetched word is zero, the block executes the word itself. That group covers short conditional branches inside the current 256-word page, a 16-bit jump through the following word, a call and a return that use R15 as a downward-growing return-stack pointer, and an immediate add and subtract on R0. It also covers a character output strobe, a load of R0 from an input port, a jump through R0 and a no-operation. For the constant load (top nibble 1), the sequencer reads the next word into the named register. It passes every other word to the execute unit with a one-cycle valid pulse.

The execute unit supplies R0 and R15 as inputs. The sequencer writes registers through a single write port. An instruction word is split into three fields: bits 15:12 are the opcode, bits 11:8 are the register or condition code, and bits 7:0 are the payload.

Top module: `page_seq`

## Requirements
- R1: While reset is asserted, the PC is 0x0000 and `memWe`, `regWe`, `outStb` and `exValid` are all low.
- R2: Each instruction other than code E of opcode 0 takes exactly two cycles. The first cycle reads memory at the PC and increments the PC. The second cycle executes the word.
- R3: Opcode 0 with codes 0 to 6 branches under these conditions: 0 always, 1 when R0>0, 2 when R0<0, 3 when R0>=0, 4 when R0<=0, 5 when R0!=0, 6 when R0==0. R0 is read as a signed 16-bit value. An untaken branch leaves the PC at the following word, in the same two cycles as a taken one.
- R4: A taken short branch sets the PC to the upper byte of the already incremented PC joined with payload bits 7:0.
- R5: Opcode 0 code 7 loads the PC with the word that follows the instruction.
- R6: Opcode 0 code 8 writes R15-1 into R15 and writes the return address (the incremented PC) to memory at R15-1. It then sets the PC to the payload zero-extended.
- R7: Opcode 0 code 9 loads the PC from memory at R15 and writes R15+1 into R15.
- R8: Opcode 0 codes A and B write R0 plus, or minus, the zero-extended payload into R0, modulo 2^16.
- R9: Opcode 0 code C raises `outStb` for one cycle, with `outData` equal to R0 bits 7:0 and `outPort` equal to the payload. Code D writes `inData` into R0.
- R10: Opcode 0 code E takes three cycles. It sets the PC to R0 and then writes the memory word at that address into R0. The next fetch reads that same address.
- R11: Opcode 1 with register field n writes the word at the incremented PC into Rn and advances the PC past that word.
- R12: Opcodes 2 to F raise `exValid` for one cycle with `exInstr` equal to the word. Opcode 0 code F changes nothing but the PC.
- R13: The PC wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 16 | Memory address |
| memRdData | input | 16 | Memory read word (asynchronous read) |
| memWrData | output | 16 | Memory write word |
| memWe | output | 1 | Memory write enable |
| accIn | input | 16 | Current R0 from the execute unit |
| spIn | input | 16 | Current R15 from the execute unit |
| regWe | output | 1 | Register write enable |
| regSel | output | 4 | Register index written |
| regWrData | output | 16 | Register write value |
| exValid | output | 1 | Hand-off pulse to the execute unit |
| exInstr | output | 16 | Instruction word handed off |
| outStb | output | 1 | Character output strobe |
| outPort | output | 8 | Output port number |
| outData | output | 8 | Output character |
| inData | input | 16 | Input port word |
| pcOut | output | 16 | Current program counter |

## Verification
The hardest case to reach is a short branch in the last word of a page. There, the incremented PC has already moved to the next page, so the target must take its upper byte from the new page. Reset only starts at address zero. The stimulus therefore first runs a 16-bit jump to 0x12FF and places the branch there, then checks that the target lands in page 0x13. The jump through R0 has a similar problem: its effect on the following fetch shows only when the fetched word is itself a constant load, so the stimulus chains the two.

// File: rtl/page_seq_pkg.sv
package page_seq_pkg;
  localparam int unsigned REG_IDX_W = 4;
  localparam logic [3:0] OP_GROUP = 4'h0;
  localparam logic [3:0] OP_CONST = 4'h1;
  localparam logic [REG_IDX_W-1:0] ACC_IDX = 4'd0;
  localparam logic [REG_IDX_W-1:0] RSP_IDX = 4'd15;

  typedef enum logic [3:0] {
    CD_ALWAYS = 4'h0, CD_GT = 4'h1, CD_LT = 4'h2, CD_GE = 4'h3,
    CD_LE = 4'h4, CD_NE = 4'h5, CD_EQ = 4'h6, CD_JUMP = 4'h7,
    CD_CALL = 4'h8, CD_RET = 4'h9, CD_ADDI = 4'hA, CD_SUBI = 4'hB,
    CD_PUT = 4'hC, CD_GET = 4'hD, CD_JACC = 4'hE, CD_IDLE = 4'hF
  } grpCode_e;

  typedef enum logic [1:0] {PC_PAGE, PC_MEM, PC_ZPAGE, PC_ACC} pcSrc_e;
  typedef enum logic [1:0] {AD_PC, AD_SP_DEC, AD_SP} adrSrc_e;
  typedef enum logic [2:0] {RW_MEM, RW_SP_DEC, RW_SP_INC, RW_ADD_IMM, RW_SUB_IMM, RW_PORT} regSrc_e;
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_INDIR} seqState_e;

  typedef struct packed {
    logic irLoad;
    logic pcInc;
    logic pcLoad;
    pcSrc_e pcSrc;
    adrSrc_e adrSrc;
    logic memWe;
    logic regWe;
    logic [REG_IDX_W-1:0] regSel;
    regSrc_e regSrc;
    logic outStb;
    logic exValid;
  } seqCtl_t;
endpackage

// File: rtl/page_seq_ctrl.sv
module page_seq_ctrl
  import page_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        irHi,
  input  logic [DATA_W-1:0] accIn,
  output seqCtl_t           ctl
);
  seqState_e state, stateNext;
  logic [3:0] opcode;
  grpCode_e code;
  logic accNeg, accZero, taken;

  assign opcode  = irHi[7:4];
  assign code    = grpCode_e'(irHi[3:0]);
  assign accNeg  = accIn[DATA_W-1];
  assign accZero = (accIn == '0);

  always_comb begin
    unique case (code)
      CD_ALWAYS: taken = 1'b1;
      CD_GT:     taken = !accNeg && !accZero;
      CD_LT:     taken = accNeg;
      CD_GE:     taken = !accNeg;
      CD_LE:     taken = accNeg || accZero;
      CD_NE:     taken = !accZero;
      CD_EQ:     taken = accZero;
      default:   taken = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= stateNext;
  end

  always_comb begin
    ctl = '0;
    ctl.pcSrc  = PC_PAGE;
    ctl.adrSrc = AD_PC;
    ctl.regSrc = RW_MEM;
    stateNext  = ST_FETCH;
    unique case (state)
      ST_FETCH: begin
        ctl.irLoad = 1'b1;
        ctl.pcInc  = 1'b1;
        stateNext  = ST_EXEC;
      end
      ST_EXEC: begin
        if (opcode == OP_GROUP) begin
          unique case (code)
            CD_ALWAYS, CD_GT, CD_LT, CD_GE, CD_LE, CD_NE, CD_EQ: begin
              ctl.pcLoad = taken;
              ctl.pcSrc  = PC_PAGE;
            end
            CD_JUMP: begin
              ctl.pcLoad = 1'b1;
              ctl.pcSrc  = PC_MEM;
            end
            CD_CALL: begin
              ctl.adrSrc = AD_SP_DEC;
              ctl.memWe  = 1'b1;
              ctl.regWe  = 1'b1;
              ctl.regSel = RSP_IDX;
              ctl.regSrc = RW_SP_DEC;
              ctl.pcLoad = 1'b1;
              ctl.pcSrc  = PC_ZPAGE;
            end
            CD_RET: begin
              ctl.adrSrc = AD_SP;
              ctl.pcLoad = 1'b1;
              ctl.pcSrc  = PC_MEM;
              ctl.regWe  = 1'b1;
              ctl.regSel = RSP_IDX;
              ctl.regSrc = RW_SP_INC;
            end
            CD_ADDI, CD_SUBI: begin
              ctl.regWe  = 1'b1;
              ctl.regSel = ACC_IDX;
              ctl.regSrc = (code == CD_ADDI) ? RW_ADD_IMM : RW_SUB_IMM;
            end
            CD_PUT: ctl.outStb = 1'b1;
            CD_GET: begin
              ctl.regWe  = 1'b1;
              ctl.regSel = ACC_IDX;
              ctl.regSrc = RW_PORT;
            end
            CD_JACC: begin
              ctl.pcLoad = 1'b1;
              ctl.pcSrc  = PC_ACC;
              stateNext  = ST_INDIR;
            end
            default: ;
          endcase
        end else if (opcode == OP_CONST) begin
          ctl.regWe  = 1'b1;
          ctl.regSel = irHi[3:0];
          ctl.regSrc = RW_MEM;
          ctl.pcInc  = 1'b1;
        end else begin
          ctl.exValid = 1'b1;
        end
      end
      ST_INDIR: begin
        ctl.regWe  = 1'b1;
        ctl.regSel = ACC_IDX;
        ctl.regSrc = RW_MEM;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/page_seq_dpath.sv
module page_seq_dpath
  import page_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PAGE_W   = 8,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] pc
);
  localparam int unsigned HI_W = DATA_W - PAGE_W;

  logic [DATA_W-1:0] pcTarget, imm, spDec, spInc;
  logic unusedCtl;

  assign unusedCtl = ^{ctl.memWe, ctl.regWe, ctl.regSel, ctl.outStb, ctl.exValid};
  assign imm   = {{HI_W{1'b0}}, ir[PAGE_W-1:0]};
  assign spDec = spIn - DATA_W'(1);
  assign spInc = spIn + DATA_W'(1);
  assign memWrData = pc;

  always_comb begin
    unique case (ctl.pcSrc)
      PC_PAGE:  pcTarget = {pc[DATA_W-1:PAGE_W], ir[PAGE_W-1:0]};
      PC_MEM:   pcTarget = memRdData;
      PC_ZPAGE: pcTarget = imm;
      default:  pcTarget = accIn;
    endcase
  end

  always_comb begin
    unique case (ctl.adrSrc)
      AD_SP_DEC: memAddr = spDec;
      AD_SP:     memAddr = spIn;
      default:   memAddr = pc;
    endcase
  end

  always_comb begin
    unique case (ctl.regSrc)
      RW_SP_DEC:  regWrData = spDec;
      RW_SP_INC:  regWrData = spInc;
      RW_ADD_IMM: regWrData = accIn + imm;
      RW_SUB_IMM: regWrData = accIn - imm;
      RW_PORT:    regWrData = inData;
      default:    regWrData = memRdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= RESET_PC;
      ir <= '0;
    end else begin
      if (ctl.irLoad) ir <= memRdData;
      if (ctl.pcLoad)     pc <= pcTarget;
      else if (ctl.pcInc) pc <= pc + DATA_W'(1);
    end
  end
endmodule

// File: rtl/page_seq.sv
module page_seq
  import page_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] spIn,
  output logic              regWe,
  output logic [3:0]        regSel,
  output logic [DATA_W-1:0] regWrData,
  output logic              exValid,
  output logic [DATA_W-1:0] exInstr,
  output logic              outStb,
  output logic [7:0]        outPort,
  output logic [7:0]        outData,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] pcOut
);
  seqCtl_t ctl;
  logic [DATA_W-1:0] ir;

  page_seq_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .irHi(ir[DATA_W-1 -: 8]), .accIn(accIn), .ctl(ctl)
  );

  page_seq_dpath #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData), .accIn(accIn),
    .spIn(spIn), .inData(inData), .memAddr(memAddr), .memWrData(memWrData),
    .regWrData(regWrData), .ir(ir), .pc(pcOut)
  );

  assign memWe   = ctl.memWe;
  assign regWe   = ctl.regWe;
  assign regSel  = ctl.regSel;
  assign exValid = ctl.exValid;
  assign exInstr = ir;
  assign outStb  = ctl.outStb;
  assign outPort = ir[7:0];
  assign outData = accIn[7:0];
endmodule

// File: rtl/page_seq_chk.sv
module page_seq_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] memAddr,
  input logic              memWe,
  input logic [DATA_W-1:0] spIn,
  input logic              regWe,
  input logic              exValid,
  input logic              outStb,
  input logic [DATA_W-1:0] pcOut
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!memWe && !regWe && !outStb && !exValid && pcOut == '0)); // R1
  AST_HANDOFF_AFTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    exValid |-> pcOut == $past(pcOut) + DATA_W'(1)); // R2
  AST_HANDOFF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    exValid |=> !exValid); // R12
  AST_PUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outStb |=> !outStb); // R9
  AST_PUSH_BELOW_SP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr == spIn - DATA_W'(1)); // R6
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe && !regWe); // R6
endmodule

bind page_seq page_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWe(memWe), .spIn(spIn),
  .regWe(regWe), .exValid(exValid), .outStb(outStb), .pcOut(pcOut)
);

// File: tb/test_page_seq.sv
module test_page_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] memAddr, memRdData, memWrData, regWrData, exInstr, pcOut;
  logic [15:0] accIn, spIn;
  logic [15:0] inData = 16'h0000;
  logic memWe, regWe, exValid, outStb;
  logic [3:0] regSel;
  logic [7:0] outPort, outData;

  logic [15:0] mem [1024];
  logic [15:0] rf [16];
  logic tbMemWe = 1'b0, tbRegWe = 1'b0;
  logic [9:0] tbMemA = '0;
  logic [3:0] tbRegI = '0;
  logic [15:0] tbD = '0;
  int nChecks = 0, nErr = 0;

  always #5 clk = ~clk;

  page_seq i_page_seq (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdData(memRdData),
    .memWrData(memWrData), .memWe(memWe), .accIn(accIn), .spIn(spIn),
    .regWe(regWe), .regSel(regSel), .regWrData(regWrData), .exValid(exValid),
    .exInstr(exInstr), .outStb(outStb), .outPort(outPort), .outData(outData),
    .inData(inData), .pcOut(pcOut)
  );

  assign memRdData = mem[memAddr[9:0]];
  assign accIn = rf[0];
  assign spIn  = rf[15];

  always @(posedge clk) begin
    if (tbMemWe) mem[tbMemA] <= tbD;
    else if (memWe) mem[memAddr[9:0]] <= memWrData;
    if (tbRegWe) rf[tbRegI] <= tbD;
    else if (regWe) rf[regSel] <= regWrData;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrMem(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); tbMemWe = 1'b1; tbMemA = a[9:0]; tbD = d;
    @(negedge clk); tbMemWe = 1'b0;
  endtask

  task automatic wrReg(input logic [3:0] i, input logic [15:0] d);
    @(negedge clk); tbRegWe = 1'b1; tbRegI = i; tbD = d;
    @(negedge clk); tbRegWe = 1'b0;
  endtask

  task automatic hold();
    @(negedge clk); rstN = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cond[20:17], acc[16:1], taken[0]
  localparam logic [20:0] BR_VEC [15] = '{
    {4'h0, 16'h8000, 1'b1}, {4'h1, 16'h0001, 1'b1}, {4'h1, 16'h0000, 1'b0},
    {4'h1, 16'h8000, 1'b0}, {4'h2, 16'hFFFF, 1'b1}, {4'h2, 16'h0000, 1'b0},
    {4'h3, 16'h0000, 1'b1}, {4'h3, 16'h8001, 1'b0}, {4'h4, 16'h0000, 1'b1},
    {4'h4, 16'hFFFE, 1'b1}, {4'h4, 16'h7FFF, 1'b0}, {4'h5, 16'h0002, 1'b1},
    {4'h5, 16'h0000, 1'b0}, {4'h6, 16'h0000, 1'b1}, {4'h6, 16'h0100, 1'b0}
  };

  initial begin
    #(200000 * 10);
    nErr++;
    nChecks++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    cyc(2);
    // R1: reset state
    check("R1 pc", pcOut, 16'h0000);
    check("R1 strobes", {12'h0, memWe, regWe, outStb, exValid}, 16'h0000);

    // R3 R2: branch condition table, two cycles whether taken or not
    for (int k = 0; k < 15; k++) begin
      hold();
      wrMem(16'h0000, {4'h0, BR_VEC[k][20:17], 8'h5A});
      wrReg(4'd0, BR_VEC[k][16:1]);
      go();
      cyc(2);
      check($sformatf("R3 cond %0h acc %h", BR_VEC[k][20:17], BR_VEC[k][16:1]),
            pcOut, BR_VEC[k][0] ? 16'h005A : 16'h0001);
    end

    // R5 then R4: jump to last word of page 0x12, branch lands in page 0x13
    hold();
    wrMem(16'h0000, 16'h0700);
    wrMem(16'h0001, 16'h12FF);
    wrMem(16'h12FF, 16'h0033);
    go();
    cyc(2);
    check("R5 jump", pcOut, 16'h12FF);
    cyc(2);
    check("R4 page target", pcOut, 16'h1333);

    // R6 call and R7 return
    hold();
    wrReg(4'd15, 16'h0200);
    wrMem(16'h0000, 16'h0830);
    wrMem(16'h0030, 16'h0900);
    go();
    cyc(2);
    check("R6 call pc", pcOut, 16'h0030);
    check("R6 call sp", rf[15], 16'h01FF);
    check("R6 call stack word", mem[10'h1FF], 16'h0001);
    cyc(2);
    check("R7 ret pc", pcOut, 16'h0001);
    check("R7 ret sp", rf[15], 16'h0200);

    // R8 immediate add/subtract with carry and borrow
    hold();
    wrReg(4'd0, 16'h00FF);
    wrMem(16'h0000, 16'h0A01);
    wrMem(16'h0001, 16'h0B03);
    wrMem(16'h0002, 16'h0BFF);
    go();
    cyc(2);
    check("R8 addi", rf[0], 16'h0100);
    cyc(2);
    check("R8 subi", rf[0], 16'h00FD);
    cyc(2);
    check("R8 subi wrap", rf[0], 16'hFFFE);

    // R9 output strobe and input port
    hold();
    wrReg(4'd0, 16'h1241);
    wrMem(16'h0000, 16'h0C7E);
    wrMem(16'h0001, 16'h0D00);
    inData = 16'hBEEF;
    go();
    cyc(1);
    check("R9 outStb high", {15'h0, outStb}, 16'h0001);
    check("R9 outPort", {8'h0, outPort}, 16'h007E);
    check("R9 outData", {8'h0, outData}, 16'h0041);
    cyc(1);
    check("R9 outStb one cycle", {15'h0, outStb}, 16'h0000);
    cyc(2);
    check("R9 in", rf[0], 16'hBEEF);

    // R10 jump through R0, then R11 constant load fetched at that address
    hold();
    wrReg(4'd0, 16'h0050);
    wrMem(16'h0000, 16'h0E00);
    wrMem(16'h0050, 16'h1234);
    wrMem(16'h0051, 16'h7777);
    go();
    cyc(2);
    check("R10 pc from acc", pcOut, 16'h0050);
    cyc(1);
    check("R10 acc loaded", rf[0], 16'h1234);
    check("R10 pc held", pcOut, 16'h0050);
    cyc(2);
    check("R11 const value", rf[2], 16'h7777);
    check("R11 pc skips word", pcOut, 16'h0052);

    // R12 hand-off and no-operation
    hold();
    wrReg(4'd0, 16'h0042);
    wrMem(16'h0000, 16'hA500);
    wrMem(16'h0001, 16'h0F12);
    go();
    cyc(1);
    check("R12 exValid", {15'h0, exValid}, 16'h0001);
    check("R12 exInstr", exInstr, 16'hA500);
    cyc(1);
    check("R12 pc after handoff", pcOut, 16'h0001);
    cyc(1);
    check("R12 nop no handoff", {15'h0, exValid}, 16'h0000);
    cyc(1);
    check("R12 nop pc", pcOut, 16'h0002);
    check("R12 nop acc kept", rf[0], 16'h0042);

    // R13 wrap
    hold();
    wrMem(16'h0000, 16'h0700);
    wrMem(16'h0001, 16'hFFFF);
    wrMem(16'hFFFF, 16'h0F00);
    go();
    cyc(2);
    check("R13 at top", pcOut, 16'hFFFF);
    cyc(2);
    check("R13 wrapped", pcOut, 16'h0000);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule